// File: doc/BRIEF.md
# 16-bit Register Byte-Access Bridge

This bridge sits between an 8-bit register bus and a peripheral whose counter, period and compare registers are 16 bits wide. Every 16-bit register occupies two neighbouring byte addresses: the even one carries bits 7:0 and the odd one carries bits 15:8. One 8-bit holding byte per instance is shared by all of the peripheral's 16-bit registers. It lets software move a whole 16-bit value in two byte transfers without the peripheral ever seeing a half-updated word.

Software must always access the low byte first. A low-byte write only parks the byte in the holding register. The high-byte write that follows then presents the complete word to the peripheral with a one-cycle write enable. A low-byte read returns the live low byte and, at the same edge, captures the live high byte into the holding register. The high-byte read that follows returns that captured byte, so both halves come from the same cycle. Because the holding byte is shared, touching the low byte of a different register between the two halves replaces its contents. The bridge does not flag this. The peripheral's hard-reset signal clears the holding byte.

Top module: `bb16_bridge`

## Requirements
- R1: While `rst` is high and after its release, `bus_rdata_o` is 0, `reg_we_o` is 0 and the holding byte is 0, so a high-byte read that follows reset returns 0.
- R2: A write to a mapped even address (register index = address/2) raises no bit of `reg_we_o` and stores the write byte in the holding byte at that clock edge.
- R3: A write to a mapped odd address raises only bit address/2 of `reg_we_o`, in the same cycle as the strobe, with `reg_wdata_o` = {write byte, holding byte}.
- R4: A read of a mapped even address puts bits 7:0 of that register's live value on `bus_rdata_o` one cycle later and loads bits 15:8 of it into the holding byte at the same edge.
- R5: A read of a mapped odd address puts the holding byte, as it was before that edge, on `bus_rdata_o` one cycle later.
- R6: The holding byte is shared: an even-address access to any other register between a register's low and high access replaces the byte the high access uses.
- R7: `hard_rst_i` clears the holding byte at the next edge and takes priority over an even-address access in the same cycle.
- R8: An access to an address whose index (address/2) is NUM_REGS or more raises no write enable and leaves the holding byte unchanged. A read of such an address returns 0 on `bus_rdata_o`.
- R9: `bus_rdata_o` keeps its value in every cycle without a read strobe.
- R10: At most one bit of `reg_we_o` is high at any time, and only while `bus_wr_i` is high.
- R11: A write or read of an odd address leaves the holding byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_rst_i | input | 1 | Peripheral hard reset; clears the holding byte |
| bus_addr_i | input | ADDR_W | Byte address; bit 0 selects the high byte |
| bus_wdata_i | input | 8 | Write byte |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Registered read byte |
| reg_live_i | input | 16*NUM_REGS | Live register values, register i at bits 16i+15:16i |
| reg_wdata_o | output | 16 | Full word presented to the peripheral |
| reg_we_o | output | NUM_REGS | One-cycle write enable per register |

## Verification
The checker assumes that the bus never raises the write and read strobes in the same cycle. It also assumes the live values are valid at the edge where a read is sampled. The bench honours both conditions: each cycle it issues at most one operation and drives every input half a period before the sampling edge. The random phase deliberately mixes in unmapped addresses, out-of-order byte accesses and hard-reset pulses, because the bridge defines a result for each of them.

// File: rtl/bb16_pkg.sv
package bb16_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int IDX_W   = 8;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic               hit;
        logic               hi_byte;
        logic [IDX_W-1:0]   idx;
    } bb_access_t;

    function automatic bb_access_t bb_classify(
        input logic             wr,
        input logic             rd,
        input logic [IDX_W:0]   addr,
        input logic [IDX_W:0]   nregs
    );
        bb_access_t a;
        a.kind    = wr ? ACC_WRITE : (rd ? ACC_READ : ACC_NONE);
        a.hi_byte = addr[0];
        a.idx     = addr[IDX_W:1];
        a.hit     = ({1'b0, addr[IDX_W:1]} < nregs);
        return a;
    endfunction

endpackage

// File: rtl/bb16_decode.sv
module bb16_decode
    import bb16_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter int ADDR_W   = 3
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output bb_access_t        acc
);
    localparam logic [IDX_W:0] NREGS_V = (IDX_W+1)'(NUM_REGS);

    logic [IDX_W:0] addr_ext;

    assign addr_ext = (IDX_W+1)'(addr);
    assign acc      = bb_classify(wr, rd, addr_ext, NREGS_V);

endmodule

// File: rtl/bb16_temp.sv
module bb16_temp
    import bb16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_rst,
    input  logic              lo_write,
    input  logic              lo_read,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [BYTE_W-1:0] live_hi,
    output logic [BYTE_W-1:0] temp_q
);
    always_ff @(posedge clk) begin
        if (rst || hard_rst) begin
            temp_q <= '0;
        end else if (lo_write) begin
            temp_q <= wr_byte;
        end else if (lo_read) begin
            temp_q <= live_hi;
        end
    end

endmodule

// File: rtl/bb16_rdpath.sv
module bb16_rdpath
    import bb16_pkg::*;
#(
    parameter int NUM_REGS = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  bb_access_t                 acc,
    input  logic [NUM_REGS*WORD_W-1:0] live_flat,
    input  logic [BYTE_W-1:0]          temp_q,
    output logic [WORD_W-1:0]          live_sel,
    output logic [BYTE_W-1:0]          rdata_q
);
    always_comb begin
        live_sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (acc.idx == IDX_W'(i)) begin
                live_sel = live_flat[i*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (acc.kind == ACC_READ) begin
            if (!acc.hit) begin
                rdata_q <= '0;
            end else if (acc.hi_byte) begin
                rdata_q <= temp_q;
            end else begin
                rdata_q <= live_sel[BYTE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/bb16_wrpath.sv
module bb16_wrpath
    import bb16_pkg::*;
#(
    parameter int NUM_REGS = 3
) (
    input  bb_access_t          acc,
    input  logic [BYTE_W-1:0]   wr_byte,
    input  logic [BYTE_W-1:0]   temp_q,
    output logic [WORD_W-1:0]   word,
    output logic [NUM_REGS-1:0] we
);
    logic hi_commit;

    assign hi_commit = (acc.kind == ACC_WRITE) && acc.hit && acc.hi_byte;
    assign word      = {wr_byte, temp_q};

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
        assign we[g] = hi_commit && (acc.idx == IDX_W'(g));
    end

endmodule

// File: rtl/bb16_bridge.sv
module bb16_bridge
    import bb16_pkg::*;
#(
    parameter  int NUM_REGS = 3,
    localparam int ADDR_W   = $clog2(2*NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hard_rst_i,
    input  logic [ADDR_W-1:0]          bus_addr_i,
    input  logic [7:0]                 bus_wdata_i,
    input  logic                       bus_wr_i,
    input  logic                       bus_rd_i,
    output logic [7:0]                 bus_rdata_o,
    input  logic [NUM_REGS*16-1:0]     reg_live_i,
    output logic [15:0]                reg_wdata_o,
    output logic [NUM_REGS-1:0]        reg_we_o
);
    bb_access_t          acc;
    logic [BYTE_W-1:0]   temp_q;
    logic [WORD_W-1:0]   live_sel;
    logic                lo_write;
    logic                lo_read;

    bb16_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_decode (
        .wr   (bus_wr_i),
        .rd   (bus_rd_i),
        .addr (bus_addr_i),
        .acc  (acc)
    );

    assign lo_write = (acc.kind == ACC_WRITE) && acc.hit && !acc.hi_byte;
    assign lo_read  = (acc.kind == ACC_READ)  && acc.hit && !acc.hi_byte;

    bb16_temp u_temp (
        .clk      (clk),
        .rst      (rst),
        .hard_rst (hard_rst_i),
        .lo_write (lo_write),
        .lo_read  (lo_read),
        .wr_byte  (bus_wdata_i),
        .live_hi  (live_sel[WORD_W-1:BYTE_W]),
        .temp_q   (temp_q)
    );

    bb16_rdpath #(.NUM_REGS(NUM_REGS)) u_rdpath (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .live_flat (reg_live_i),
        .temp_q    (temp_q),
        .live_sel  (live_sel),
        .rdata_q   (bus_rdata_o)
    );

    bb16_wrpath #(.NUM_REGS(NUM_REGS)) u_wrpath (
        .acc     (acc),
        .wr_byte (bus_wdata_i),
        .temp_q  (temp_q),
        .word    (reg_wdata_o),
        .we      (reg_we_o)
    );

endmodule

// File: rtl/bb16_bridge_chk.sv
module bb16_bridge_chk #(
    parameter  int NUM_REGS = 3,
    localparam int ADDR_W   = $clog2(2*NUM_REGS)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   hard_rst_i,
    input logic [ADDR_W-1:0]      bus_addr_i,
    input logic [7:0]             bus_wdata_i,
    input logic                   bus_wr_i,
    input logic                   bus_rd_i,
    input logic [7:0]             bus_rdata_o,
    input logic [NUM_REGS*16-1:0] reg_live_i,
    input logic [15:0]            reg_wdata_o,
    input logic [NUM_REGS-1:0]    reg_we_o,
    input logic [7:0]             temp_q
);
    logic        mapped;
    logic        odd;
    logic [15:0] obs_live;

    assign mapped = (int'(bus_addr_i) / 2) < NUM_REGS;
    assign odd    = bus_addr_i[0];

    always_comb begin
        obs_live = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(bus_addr_i) / 2 == i) obs_live = reg_live_i[i*16 +: 16];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (bus_rdata_o == 8'h00 && temp_q == 8'h00)); // R1

    AST_LO_WRITE_PARKS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && mapped && !odd && !hard_rst_i) |=> temp_q == $past(bus_wdata_i)); // R2

    AST_HI_WRITE_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && mapped && odd) |-> (reg_wdata_o == {bus_wdata_i, temp_q} && $countones(reg_we_o) == 1)); // R3

    AST_LO_READ_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && !bus_wr_i && mapped && !odd) |=> bus_rdata_o == $past(obs_live[7:0])); // R4

    AST_LO_READ_LATCH: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && !bus_wr_i && mapped && !odd && !hard_rst_i) |=> temp_q == $past(obs_live[15:8])); // R4

    AST_HI_READ_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && !bus_wr_i && mapped && odd) |=> bus_rdata_o == $past(temp_q)); // R5

    AST_HARD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hard_rst_i |=> temp_q == 8'h00); // R7

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr_i || bus_rd_i) && !mapped && !hard_rst_i) |=> $stable(temp_q)); // R8

    AST_UNMAPPED_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> reg_we_o == '0); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd_i && !bus_wr_i) |=> $stable(bus_rdata_o)); // R9

    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_we_o)); // R10

    AST_WE_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
        (reg_we_o != '0) |-> bus_wr_i); // R10

    AST_HI_KEEPS_TEMP: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr_i || bus_rd_i) && odd && !hard_rst_i) |=> $stable(temp_q)); // R11

endmodule

bind bb16_bridge bb16_bridge_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hard_rst_i  (hard_rst_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_rdata_o (bus_rdata_o),
    .reg_live_i  (reg_live_i),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .temp_q      (temp_q)
);

// File: tb/bb16_bridge_test.sv
`timescale 1ns/1ps
module bb16_bridge_test;
    localparam int N  = 3;
    localparam int AW = $clog2(2*N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hard_rst_i = 1'b0;
    logic [AW-1:0] bus_addr_i = '0;
    logic [7:0]    bus_wdata_i = '0;
    logic          bus_wr_i = 1'b0;
    logic          bus_rd_i = 1'b0;
    logic [7:0]    bus_rdata_o;
    logic [N*16-1:0] reg_live_i;
    logic [15:0]   reg_wdata_o;
    logic [N-1:0]  reg_we_o;

    logic [15:0] live [N];
    logic [7:0]  m_temp;
    logic [7:0]  m_rdata;
    string       prev_tag;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) reg_live_i[i*16 +: 16] = live[i];
    end

    bb16_bridge #(.NUM_REGS(N)) uut (
        .clk(clk), .rst(rst), .hard_rst_i(hard_rst_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_rdata_o(bus_rdata_o),
        .reg_live_i(reg_live_i), .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: drive, compare against the model, advance the model
    task automatic step(input logic wr, input logic rd, input int addr,
                        input logic [7:0] wd, input logic hr);
        int   idx;
        bit   mapped, odd;
        logic [31:0] exp_we;
        logic [7:0]  nt;
        bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = AW'(addr);
        bus_wdata_i = wd; hard_rst_i = hr;
        #2;
        idx = addr / 2; mapped = idx < N; odd = (addr % 2) == 1;
        check(prev_tag, 32'(bus_rdata_o), 32'(m_rdata));
        exp_we = (wr && mapped && odd) ? (32'd1 << idx) : 32'd0;
        check(wr ? (mapped ? (odd ? "R3" : "R2") : "R8") : "R10", 32'(reg_we_o), exp_we);
        if (exp_we != 0) check("R3", 32'(reg_wdata_o), {16'd0, wd, m_temp});
        nt = m_temp;
        if (wr && mapped && !odd) nt = wd;
        if (wr && mapped && odd) live[idx] = {wd, m_temp};
        if (rd && !wr) begin
            if (!mapped) m_rdata = 8'h00;
            else if (odd) m_rdata = m_temp;
            else begin m_rdata = live[idx][7:0]; nt = live[idx][15:8]; end
            prev_tag = !mapped ? "R8" : (odd ? "R5" : "R4");
        end else begin
            prev_tag = "R9";
        end
        if (hr) nt = 8'h00;
        m_temp = nt;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) live[i] = 16'h0;
        m_temp = 8'h00; m_rdata = 8'h00; prev_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1", 32'(bus_rdata_o), 0);
        check("R1", 32'(reg_we_o), 0);
        @(negedge clk);
        step(0, 1, 1, 8'h00, 0);
        check("R1", 32'(bus_rdata_o), 0);
        // full word write to register 1
        step(1, 0, 2, 8'h34, 0);
        step(1, 0, 3, 8'h12, 0);
        check("R3", 32'(live[1]), 32'h1234);
        // atomic read: live value changes between the halves
        live[1] = 16'hBEEF;
        step(0, 1, 2, 8'h00, 0);
        check("R4", 32'(bus_rdata_o), 32'hEF);
        live[1] = 16'h0000;
        step(0, 1, 3, 8'h00, 0);
        check("R5", 32'(bus_rdata_o), 32'hBE);
        step(0, 0, 0, 8'h00, 0);
        step(0, 0, 0, 8'h00, 0);
        check("R9", 32'(bus_rdata_o), 32'hBE);
        // shared holding byte gets overwritten by another register
        live[0] = 16'h1111;
        step(0, 1, 0, 8'h00, 0);
        step(1, 0, 4, 8'h77, 0);
        step(0, 1, 1, 8'h00, 0);
        check("R6", 32'(bus_rdata_o), 32'h77);
        // hard reset beats a simultaneous low write, and clears alone
        step(1, 0, 0, 8'h55, 1);
        step(0, 1, 1, 8'h00, 0);
        check("R7", 32'(bus_rdata_o), 0);
        step(1, 0, 0, 8'h66, 0);
        step(0, 0, 0, 8'h00, 1);
        step(0, 1, 5, 8'h00, 0);
        check("R7", 32'(bus_rdata_o), 0);
        // unmapped addresses
        step(1, 0, 2, 8'hAA, 0);
        step(1, 0, 6, 8'h99, 0);
        step(0, 1, 7, 8'h00, 0);
        check("R8", 32'(bus_rdata_o), 0);
        step(0, 1, 1, 8'h00, 0);
        check("R8", 32'(bus_rdata_o), 32'hAA);
        // odd-address access leaves holding byte alone
        step(1, 0, 0, 8'h21, 0);
        step(1, 0, 1, 8'h43, 0);
        step(0, 1, 5, 8'h00, 0);
        check("R11", 32'(bus_rdata_o), 32'h21);
        // random mix
        for (int k = 0; k < 600; k++) begin
            int op;
            for (int i = 0; i < N; i++) live[i] = 16'($urandom);
            op = $urandom_range(0, 2);
            step(op == 1, op == 2, $urandom_range(0, 2*N+1) % (1 << AW),
                 8'($urandom), ($urandom_range(0, 15) == 0));
        end
        step(0, 0, 0, 8'h00, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule